// File: doc/BRIEF.md
# Floppy Drive Steering and Output Register

This block holds the output control register of a floppy disk controller and turns it into the physical drive-select and motor-enable pins. The host writes the register over a simple strobed bus. The drive number and the motor bits in that register are logical numbers. A boot-map setting in a second configuration register can exchange logical drive 0 with physical drive 1 or physical drive 2. This lets a drive other than physical drive 0 act as the boot drive without any software change.

The same configuration register names one logical drive as a tape unit. A tape-mode output is raised while that drive is selected. One bit in the output register opens a DMA path. While that bit is set, a DMA acknowledge together with a read or write strobe acts as an internal chip select for the data path, whether or not the external chip select is present. The select and motor pins are registered, so each pin changes once per write and without glitches.

Top module: `fdc_drive_steer`

## Requirements
- R1: A synchronous active-low reset clears the output register, the boot map and the tape field to zero. Afterwards drv_sel_n reads 4'b1110, mot_en_n reads 4'b1111, tape_mode reads 0 and ctrl_rst_n reads 0.
- R2: When host_cs_n and host_wr_n are both low at a rising edge and host_addr is 0, host_wdata is captured into the output register. The fields are: bits 1:0 logical drive, bit 2 soft-run (driven out as ctrl_rst_n), bit 3 DMA gate, bits 7:4 motor bits for logical drives 0 to 3. The select, motor and tape pins follow on the next rising edge.
- R3: The same write strobe with host_addr at 1 loads the configuration register. Bits 1:0 hold the tape field and bits 5:4 hold the boot map.
- R4: A write strobe is ignored while host_cs_n is high or host_wr_n is high. The pins keep their previous values.
- R5: Boot map 00 and boot map 11 both connect each logical drive to the physical drive of the same number.
- R6: Boot map 01 exchanges drives 0 and 1. Drives 2 and 3 pass through unchanged.
- R7: Boot map 10 exchanges drives 0 and 2. A logical drive 0 asserts physical select 2 and motor 2, and drives 1 and 3 pass through unchanged.
- R8: Each motor bit is routed through the same logical-to-physical map as the drive number.
- R9: Exactly one bit of drv_sel_n is low at every clock edge. All select and motor outputs are active low.
- R10: tape_mode is high when the tape field is not zero and the logical drive equals the tape field. A tape field of 00 never raises tape_mode.
- R11: int_cs_n is low when host_cs_n is low. It is also low when the DMA gate bit is set, dma_ack_n is low, and host_rd_n or host_wr_n is low. When the gate bit is clear, dma_ack_n has no effect.
- R12: Writing 8'h0C to the output register sets the DMA gate bit and the soft-run bit together. It selects logical drive 0 with every motor off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_cs_n | input | 1 | External chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_addr | input | 1 | Register address: 0 output register, 1 configuration |
| host_wdata | input | 8 | Host write data |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| drv_sel_n | output | 4 | Physical drive selects, active low |
| mot_en_n | output | 4 | Physical motor enables, active low |
| tape_mode | output | 1 | Selected drive is the tape unit |
| ctrl_rst_n | output | 1 | Soft reset to the rest of the controller, active low |
| int_cs_n | output | 1 | Internal chip select, active low |

## Verification
Some properties are checked at every edge by the assertions. These are the reset value of the register, capture on a qualified write, the register holding still when no write is qualified, and a single active select. They also cover the number of running motors being preserved across the map, the tape output staying low under a zero tape field, and the two conditions of the internal chip select. Other behaviour can only be shown by the bench's scenarios. This covers the exact physical pin each boot map picks for each logical drive and motor, drives 2 and 3 passing through unchanged, map 11 aliasing map 00, and the tape output following the selected logical drive. It also covers the one-edge delay from a captured write to the pins.

// File: rtl/fds_pkg.sv
// Shared types and the logical-to-physical drive map.
// Assumes four drives, addressed by a two-bit drive number.
package fds_pkg;
    localparam int DRV_W   = 2;
    localparam int NUM_DRV = 1 << DRV_W;

    typedef enum logic [1:0] {
        BOOT_NATIVE = 2'b00,
        BOOT_SWAP01 = 2'b01,
        BOOT_SWAP02 = 2'b10,
        BOOT_ALIAS  = 2'b11
    } boot_map_e;

    // Output register layout, MSB first.
    typedef struct packed {
        logic [NUM_DRV-1:0] motor;
        logic               dma_gate;
        logic               soft_run;
        logic [DRV_W-1:0]   drive;
    } outreg_t;

    // Drive 0 trades places with a partner drive, and every other drive maps to itself.
    // The map is its own inverse, so the same function works in both directions.
    function automatic logic [DRV_W-1:0] steer(input logic [DRV_W-1:0] d,
                                               input boot_map_e m);
        logic [DRV_W-1:0] partner;
        case (m)
            BOOT_SWAP01: partner = DRV_W'(1);
            BOOT_SWAP02: partner = DRV_W'(2);
            default:     partner = '0;
        endcase
        if (d == '0)
            return partner;
        else if (d == partner)
            return '0;
        else
            return d;
    endfunction
endpackage

// File: rtl/fds_host_regs.sv
// Host-written output register and configuration register.
// Assumes the bus strobes are synchronous to clk. A write happens on any edge
// where the chip select and the write strobe are both low.
module fds_host_regs
    import fds_pkg::*;
#(
    parameter int ADDR_W   = 1,
    parameter int DATA_W   = 8,
    parameter int TAPE_LSB = 0,
    parameter int BOOT_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output outreg_t           outreg_o,
    output logic [DRV_W-1:0]  tape_sel_o,
    output boot_map_e         boot_sel_o
);
    localparam logic [ADDR_W-1:0] ADDR_OUT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(1);

    logic wr_en;
    assign wr_en = !cs_n && !wr_n;

    // Output register: load on a qualified write to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outreg_o <= '0;
        else if (wr_en && addr == ADDR_OUT)
            outreg_o <= outreg_t'(wdata);
    end

    // Configuration register: tape field and boot map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tape_sel_o <= '0;
            boot_sel_o <= BOOT_NATIVE;
        end else if (wr_en && addr == ADDR_CFG) begin
            tape_sel_o <= wdata[TAPE_LSB +: DRV_W];
            boot_sel_o <= boot_map_e'(wdata[BOOT_LSB +: 2]);
        end
    end

    a_r1_out_reset: assert property (@(posedge clk)
        !rst_n |=> (outreg_o == '0 && tape_sel_o == '0 && boot_sel_o == BOOT_NATIVE));

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && addr == ADDR_OUT) |=> (outreg_o == $past(wdata)));

    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr_n) |=> ($stable(outreg_o) && $stable(tape_sel_o) && $stable(boot_sel_o)));
endmodule

// File: rtl/fds_drive_steer.sv
// Maps logical drive number and motor bits onto registered physical pins.
// Assumes the boot map is an involution, as steer() guarantees.
module fds_drive_steer
    import fds_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  outreg_t            outreg_i,
    input  logic [DRV_W-1:0]   tape_sel_i,
    input  boot_map_e          boot_sel_i,
    output logic [NUM_DRV-1:0] drv_sel_n,
    output logic [NUM_DRV-1:0] mot_en_n,
    output logic               tape_mode
);
    localparam logic [NUM_DRV-1:0] SEL_RST = ~(NUM_DRV'(1));

    logic [NUM_DRV-1:0] sel_nxt;
    logic [NUM_DRV-1:0] mot_nxt;
    logic               tape_nxt;

    for (genvar p = 0; p < NUM_DRV; p++) begin : g_phys
        logic [DRV_W-1:0] virt;
        // Find the logical drive that lands on physical drive p.
        always_comb virt = steer(DRV_W'(p), boot_sel_i);
        assign sel_nxt[p] = ~(outreg_i.drive == virt);
        assign mot_nxt[p] = ~outreg_i.motor[virt];
    end

    // Tape mode compares the tape field with the logical drive. Zero means none.
    assign tape_nxt = (tape_sel_i != '0) && (outreg_i.drive == tape_sel_i);

    // Pin registers: one update per edge, so the pins do not glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_sel_n <= SEL_RST;
            mot_en_n  <= '1;
            tape_mode <= 1'b0;
        end else begin
            drv_sel_n <= sel_nxt;
            mot_en_n  <= mot_nxt;
            tape_mode <= tape_nxt;
        end
    end

    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~drv_sel_n) == 1);

    a_r10_tape_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tape_sel_i == '0) |=> !tape_mode);

    a_r7_boot_drive2: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_sel_i == BOOT_SWAP02 && outreg_i.drive == '0) |=> !drv_sel_n[2]);
endmodule

// File: rtl/fds_chip_sel.sv
// Internal chip select: the external select, or DMA acknowledge with a strobe
// while the gate is open. Purely combinational. Assumes active-low strobes.
module fds_chip_sel (
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic dma_ack_n,
    input  logic dma_gate,
    output logic int_cs_n
);
    logic dma_hit;

    // Combine the DMA path with the external select.
    always_comb begin
        dma_hit  = dma_gate && !dma_ack_n && (!rd_n || !wr_n);
        int_cs_n = !(!cs_n || dma_hit);
    end
endmodule

// File: rtl/fdc_drive_steer.sv
// Top of the drive steering block: registers, drive map and internal chip select.
// Assumes all inputs are synchronous to clk.
module fdc_drive_steer
    import fds_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs_n,
    input  logic               host_wr_n,
    input  logic               host_rd_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               dma_ack_n,
    output logic [NUM_DRV-1:0] drv_sel_n,
    output logic [NUM_DRV-1:0] mot_en_n,
    output logic               tape_mode,
    output logic               ctrl_rst_n,
    output logic               int_cs_n
);
    outreg_t          outreg_q;
    logic [DRV_W-1:0] tape_sel_q;
    boot_map_e        boot_sel_q;

    fds_host_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (host_cs_n),
        .wr_n       (host_wr_n),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .outreg_o   (outreg_q),
        .tape_sel_o (tape_sel_q),
        .boot_sel_o (boot_sel_q)
    );

    fds_drive_steer steer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .outreg_i   (outreg_q),
        .tape_sel_i (tape_sel_q),
        .boot_sel_i (boot_sel_q),
        .drv_sel_n  (drv_sel_n),
        .mot_en_n   (mot_en_n),
        .tape_mode  (tape_mode)
    );

    fds_chip_sel csel_i (
        .cs_n      (host_cs_n),
        .rd_n      (host_rd_n),
        .wr_n      (host_wr_n),
        .dma_ack_n (dma_ack_n),
        .dma_gate  (outreg_q.dma_gate),
        .int_cs_n  (int_cs_n)
    );

    // The soft-run bit drives the controller's reset directly.
    assign ctrl_rst_n = outreg_q.soft_run;

    a_r8_motor_count: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(~mot_en_n) == $countones($past(outreg_q.motor))));

    a_r11_dma_path: assert property (@(posedge clk) disable iff (!rst_n)
        (outreg_q.dma_gate && !dma_ack_n && (!host_rd_n || !host_wr_n)) |-> !int_cs_n);

    a_r11_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!outreg_q.dma_gate && host_cs_n) |-> int_cs_n);
endmodule

// File: tb/fdc_drive_steer_tb_top.sv
`timescale 1ns/1ps
module fdc_drive_steer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic       host_rd_n = 1'b1;
    logic [0:0] host_addr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       dma_ack_n = 1'b1;
    logic [3:0] drv_sel_n;
    logic [3:0] mot_en_n;
    logic       tape_mode;
    logic       ctrl_rst_n;
    logic       int_cs_n;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [3:0] sel;
        logic [3:0] mot;
        logic       tape;
        logic       run;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    // Model state, updated from the requirements only.
    logic [7:0] m_out = 8'h00;
    logic [1:0] m_tape = 2'b00;
    logic [1:0] m_boot = 2'b00;

    always #4 clk = ~clk;

    fdc_drive_steer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs_n  (host_cs_n),
        .host_wr_n  (host_wr_n),
        .host_rd_n  (host_rd_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .dma_ack_n  (dma_ack_n),
        .drv_sel_n  (drv_sel_n),
        .mot_en_n   (mot_en_n),
        .tape_mode  (tape_mode),
        .ctrl_rst_n (ctrl_rst_n),
        .int_cs_n   (int_cs_n)
    );

    function automatic logic [1:0] map_drv(input logic [1:0] d, input logic [1:0] b);
        logic [1:0] pr;
        pr = (b == 2'b01) ? 2'd1 : (b == 2'b10) ? 2'd2 : 2'd0;
        if (d == 2'd0) return pr;
        if (d == pr) return 2'd0;
        return d;
    endfunction

    function automatic exp_t model(input string req);
        exp_t e;
        e.sel = ~(4'b0001 << map_drv(m_out[1:0], m_boot));
        for (int p = 0; p < 4; p++)
            e.mot[p] = ~m_out[4 + map_drv(2'(p), m_boot)];
        e.tape = (m_tape != 2'b00) && (m_out[1:0] == m_tape);
        e.run = m_out[2];
        e.req = req;
        return e;
    endfunction

    task automatic chk(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: one bus write, then an expected item once the pins have updated.
    task automatic host_write(input logic a, input logic [7:0] d, input logic cs,
                              input logic wr, input string req);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_cs_n = cs; host_wr_n = wr;
        @(negedge clk);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        if (!cs && !wr) begin
            if (a == 1'b0) m_out = d;
            else begin m_tape = d[1:0]; m_boot = d[5:4]; end
        end
        @(posedge clk);
        sb_q.push_back(model(req));
    endtask

    // Monitor: compare pins against the scoreboard away from the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, "drv_sel_n", {4'h0, drv_sel_n}, {4'h0, e.sel});
                chk(e.req, "mot_en_n", {4'h0, mot_en_n}, {4'h0, e.mot});
                chk(e.req, "tape_mode", {7'h0, tape_mode}, {7'h0, e.tape});
                chk(e.req, "ctrl_rst_n", {7'h0, ctrl_rst_n}, {7'h0, e.run});
            end
        end
    end

    task automatic cs_probe(input logic cs, input logic rd, input logic wr,
                            input logic ack, input logic exp, input string req);
        @(negedge clk);
        host_cs_n = cs; host_rd_n = rd; host_wr_n = wr; dma_ack_n = ack;
        host_addr = 1'b1; host_wdata = 8'h00;
        #1;
        chk(req, "int_cs_n", {7'h0, int_cs_n}, {7'h0, exp});
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; dma_ack_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog R1..: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk("R1", "drv_sel_n", {4'h0, drv_sel_n}, 8'h0E);
        chk("R1", "mot_en_n", {4'h0, mot_en_n}, 8'h0F);
        chk("R1", "tape_mode", {7'h0, tape_mode}, 8'h00);
        chk("R1", "ctrl_rst_n", {7'h0, ctrl_rst_n}, 8'h00);
        chk("R1", "int_cs_n", {7'h0, int_cs_n}, 8'h01);

        host_write(1'b0, 8'h0C, 1'b0, 1'b0, "R12");
        cs_probe(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R12");      // gate set: DMA read selects
        host_write(1'b0, 8'hF1, 1'b0, 1'b0, "R2");
        host_write(1'b0, 8'h87, 1'b0, 1'b0, "R5");
        host_write(1'b0, 8'h26, 1'b0, 1'b0, "R2");
        // R3 and R6: boot map 01
        host_write(1'b1, 8'h10, 1'b0, 1'b0, "R3");
        host_write(1'b0, 8'h1C, 1'b0, 1'b0, "R6");
        host_write(1'b0, 8'h2D, 1'b0, 1'b0, "R6");
        host_write(1'b0, 8'h8F, 1'b0, 1'b0, "R6");
        // R7 and R8: boot map 10
        host_write(1'b1, 8'h20, 1'b0, 1'b0, "R3");
        host_write(1'b0, 8'h1C, 1'b0, 1'b0, "R7");
        host_write(1'b0, 8'h4E, 1'b0, 1'b0, "R7");
        host_write(1'b0, 8'h2D, 1'b0, 1'b0, "R7");
        host_write(1'b0, 8'h54, 1'b0, 1'b0, "R8");
        // R5: map 11 behaves like 00
        host_write(1'b1, 8'h30, 1'b0, 1'b0, "R5");
        host_write(1'b0, 8'h1C, 1'b0, 1'b0, "R5");
        host_write(1'b0, 8'h46, 1'b0, 1'b0, "R5");
        // R10: tape field
        host_write(1'b1, 8'h02, 1'b0, 1'b0, "R3");
        host_write(1'b0, 8'h0E, 1'b0, 1'b0, "R10");
        host_write(1'b0, 8'h0D, 1'b0, 1'b0, "R10");
        host_write(1'b1, 8'h00, 1'b0, 1'b0, "R10");
        host_write(1'b0, 8'h0C, 1'b0, 1'b0, "R10");
        // R4: unqualified strobes leave everything alone
        host_write(1'b0, 8'hFF, 1'b1, 1'b0, "R4");
        host_write(1'b0, 8'hFF, 1'b0, 1'b1, "R4");
        host_write(1'b1, 8'h23, 1'b1, 1'b0, "R4");
        host_write(1'b0, 8'h1C, 1'b0, 1'b0, "R4");
        // R11: internal chip select
        host_write(1'b0, 8'h0C, 1'b0, 1'b0, "R11");
        cs_probe(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
        cs_probe(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R11");
        cs_probe(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R11");
        host_write(1'b0, 8'h04, 1'b0, 1'b0, "R11");
        cs_probe(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        cs_probe(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
        repeat (3) @(negedge clk);
        chk("R9", "drv_sel one-hot", 8'($countones(~drv_sel_n)), 8'd1);
        finish_run();
    end
endmodule